// File: doc/BRIEF.md
# Error Interrupt Status Register

This is an eight-bit sticky status register that collects error events for a full-speed USB controller. The packet checker, the bus turnaround timer and the DMA logic each send a one-cycle pulse when they detect a fault. Each pulse sets its own status bit on the next clock edge, without waiting for the token to finish. A bit stays set until software writes a one to that bit position.

An eight-bit enable register sits beside the status register. The summary output `error_o` is high whenever any status bit is set while its enable bit is also set. This output feeds a parent interrupt status register, which is outside this block.

Software reaches both registers through a simple register port with a one-bit address. Address 0 selects the status register and address 1 selects the enable register.

Top module: `err_irq_stat`

## Requirements
- R1: After reset, the status register reads 0x00, the enable register reads 0x00 and `error_o` is low.
- R2: Status bit 6 is reserved. It always reads 0. A write of one to bit 6 of the status register does not set it, and no input sets it.
- R3: The status bits map to the inputs as follows: bit 7 `stuff_err_i`, bit 5 `dma_err_i`, bit 4 `turn_tmo_i`, bit 3 `frag_err_i`, bit 2 `crc16_err_i`, bit 1 `crc5_err_i` and bit 0 `pid_err_i`.
- R4: A pulse on an error input shows as a set status bit on the port right after the next rising clock edge.
- R5: A write to address 0 clears each status bit whose write-data bit is 1. Bits written with 0 keep their value, and set bits stay set when no write occurs.
- R6: If an error pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: A read of address 0 returns the raw latched status, whatever the enable bits hold.
- R8: The enable register at address 1 is a plain eight-bit read/write register. A write to it takes effect at the next rising clock edge.
- R9: `error_o` equals the OR of all status bits ANDed with their enable bits, and it follows the registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stuff_err_i | input | 1 | Bit-stuff error pulse |
| dma_err_i | input | 1 | DMA late or overflow error pulse |
| turn_tmo_i | input | 1 | Bus turnaround timeout pulse |
| frag_err_i | input | 1 | Data field was not a whole number of bytes |
| crc16_err_i | input | 1 | Data packet CRC16 failure pulse |
| crc5_err_i | input | 1 | Token CRC5 failure pulse |
| pid_err_i | input | 1 | PID check failure pulse |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 1 | 0 for status, 1 for enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| error_o | output | 1 | Summary of enabled status bits |

## Verification
The hardest case to reach is a clearing write and a new error pulse landing on the same bit in the same cycle. Both must arrive on one edge, against a bit that is already set. The bench first latches a pattern of errors. It then drives a second pulse pattern together with an all-ones clear write. The result must be exactly the second pattern. This is repeated over many pulse patterns and across all 256 enable values, so the summary output is checked against every mask.

// File: rtl/err_irq_stat.sv
module err_irq_stat #(
  parameter logic [7:0] RSVD_MASK = 8'h40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stuff_err_i,
  input  logic       dma_err_i,
  input  logic       turn_tmo_i,
  input  logic       frag_err_i,
  input  logic       crc16_err_i,
  input  logic       crc5_err_i,
  input  logic       pid_err_i,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       error_o
);
  logic [7:0] stat, en, hit, clr;
  logic       wr_stat, wr_en;

  assign hit     = {stuff_err_i, 1'b0, dma_err_i, turn_tmo_i,
                    frag_err_i, crc16_err_i, crc5_err_i, pid_err_i};
  assign wr_stat = bus_sel & bus_wr & ~bus_addr;
  assign wr_en   = bus_sel & bus_wr & bus_addr;
  assign clr     = wr_stat ? bus_wdata : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= 8'h00;
      en   <= 8'h00;
    end else begin
      stat <= ((stat & ~clr) | hit) & ~RSVD_MASK;
      if (wr_en) en <= bus_wdata;
    end
  end

  assign bus_rdata = bus_addr ? en : stat;
  assign error_o   = |(stat & en);
endmodule

module err_irq_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stuff_err_i,
  input logic       dma_err_i,
  input logic       turn_tmo_i,
  input logic       frag_err_i,
  input logic       crc16_err_i,
  input logic       crc5_err_i,
  input logic       pid_err_i,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic       bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [7:0] stat
);
  logic [7:0] pv, cm;
  assign pv = {stuff_err_i, 1'b0, dma_err_i, turn_tmo_i,
               frag_err_i, crc16_err_i, crc5_err_i, pid_err_i};
  assign cm = (bus_sel && bus_wr && !bus_addr) ? bus_wdata : 8'h00;

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr |-> !bus_rdata[6]);

  p_set_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pv != 8'h00) |=> ((stat & $past(pv)) == $past(pv)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat != 8'h00) |=> ((($past(stat) & ~$past(cm)) & ~stat) == 8'h00));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cm & ~pv) != 8'h00) |=> ((stat & $past(cm & ~pv)) == 8'h00));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cm & pv) != 8'h00) |=> ((stat & $past(cm & pv)) == $past(cm & pv)));
endmodule

bind err_irq_stat err_irq_stat_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .stuff_err_i(stuff_err_i), .dma_err_i(dma_err_i), .turn_tmo_i(turn_tmo_i),
  .frag_err_i(frag_err_i), .crc16_err_i(crc16_err_i), .crc5_err_i(crc5_err_i),
  .pid_err_i(pid_err_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .stat(stat)
);

// File: tb/sim_err_irq_stat.sv
`timescale 1ns/1ps
module sim_err_irq_stat;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] src = 7'h00;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       error_o;
  int         vectors = 0, errors = 0;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  err_irq_stat u0 (
    .clk(clk), .rst_n(rst_n),
    .stuff_err_i(src[6]), .dma_err_i(src[5]), .turn_tmo_i(src[4]),
    .frag_err_i(src[3]), .crc16_err_i(src[2]), .crc5_err_i(src[1]),
    .pid_err_i(src[0]),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .error_o(error_o)
  );

  function automatic logic [7:0] map_src(input logic [6:0] s);
    return {s[6], 1'b0, s[5:0]};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic [6:0] s, input logic wr, input logic a, input logic [7:0] d);
    src = s; bus_sel = wr; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    src = 7'h00; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
    #1 v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    #150000;
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog actual=00 expected=01");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, exp_s;
    repeat (2) @(negedge clk);
    rd(1'b0, v); check("R1 status reset", v, 8'h00);
    rd(1'b1, v); check("R1 enable reset", v, 8'h00);
    check("R1 error reset", {7'h0, error_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 7; i++) begin
      cycle(7'(1 << i), 1'b0, 1'b0, 8'h00);
      rd(1'b0, v); check("R3 R4 single source map", v, map_src(7'(1 << i)));
      cycle(7'h00, 1'b1, 1'b0, 8'hFF);
    end

    cycle(7'h00, 1'b1, 1'b0, 8'h40);
    rd(1'b0, v); check("R2 reserved write", v, 8'h00);
    cycle(7'h7F, 1'b0, 1'b0, 8'h00);
    rd(1'b0, v); check("R2 reserved under all pulses", v, 8'hBF);
    cycle(7'h00, 1'b0, 1'b0, 8'h00);
    rd(1'b0, v); check("R5 hold without write", v, 8'hBF);
    cycle(7'h00, 1'b1, 1'b0, 8'h00);
    rd(1'b0, v); check("R5 write zero no effect", v, 8'hBF);
    cycle(7'h00, 1'b1, 1'b0, 8'hFF);
    rd(1'b0, v); check("R5 clear all", v, 8'h00);

    for (int e = 0; e < 256; e++) begin
      cycle(7'h00, 1'b1, 1'b1, 8'(e));
      rd(1'b1, v); check("R8 enable readback", v, 8'(e));
      for (int k = 0; k < 8; k++) begin
        logic [6:0] p, q;
        logic [7:0] m;
        p = 7'((e * 37 + k * 11) & 8'h7F);
        q = 7'((e * 13 + k * 29 + 5) & 8'h7F);
        m = 8'((e * 7 + k * 53 + 3) & 8'hFF);
        cycle(p, 1'b0, 1'b0, 8'h00);
        exp_s = map_src(p);
        rd(1'b0, v); check("R4 R7 raw status", v, exp_s);
        check("R9 summary", {7'h0, error_o}, {7'h0, |(exp_s & 8'(e))});
        cycle(7'h00, 1'b1, 1'b0, m);
        exp_s = exp_s & ~m;
        rd(1'b0, v); check("R5 partial clear", v, exp_s);
        check("R9 summary after clear", {7'h0, error_o}, {7'h0, |(exp_s & 8'(e))});
        cycle(q, 1'b1, 1'b0, 8'hFF);
        exp_s = map_src(q);
        rd(1'b0, v); check("R6 set wins over clear", v, exp_s);
        cycle(7'h00, 1'b1, 1'b0, 8'hFF);
      end
    end

    rd(1'b1, v); check("R8 enable kept", v, 8'hFF);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule